// File: doc/BRIEF.md
# Flyback Protection Fault Manager

This block decides when a quasi-resonant flyback controller must stop switching and how it comes back. Once per switching cycle a strobe marks the end of the cycle. At that strobe the block samples four comparator flags: output overvoltage and output undervoltage (both taken when demagnetisation ends), the hiccup overcurrent level on the sense input, and over-temperature. It does not trip on a single noisy sample. Overvoltage and undervoltage must persist over a run of consecutive cycles. Overcurrent uses a two-strike warning. Undervoltage is ignored during a blanking window after power-on and after every restart.

After a trip the block raises a shutdown request. It then steps through the supply sequence that fits the fault, using flags that report where the supply stands: below the restart level, below the off level, or at the turn-on level. A recharge request asks the startup generator to refill the supply. The overvoltage response is picked by a configuration bit, either auto-restart or latched. One sticky status bit per fault records which fault caused the stop.

The controller has five states:
- RUN: switching is allowed.
- DRAIN: waits for the supply to fall below the restart level.
- CHARGE: recharges the supply to the turn-on level.
- LATCH: latched overvoltage.
- THERM: thermal stop.

The transitions are:
- RUN→DRAIN on an overcurrent, undervoltage or auto-restart overvoltage trip.
- RUN→LATCH on an overvoltage trip in latched mode.
- RUN→THERM on an over-temperature trip.
- DRAIN→CHARGE when the supply is below the restart level.
- CHARGE→RUN (restart) when the supply reaches turn-on.
- LATCH→CHARGE when the supply is below the restart level with mains absent.
- THERM→RUN (restart) when the part has cooled and the supply is at turn-on.

Top module: `flyback_fault_mgr`

## Requirements
- R1: Overvoltage trips only at the fourth consecutive cycle-end strobe with `ovp_hit` high (count `OVP_STREAK`). A strobe with `ovp_hit` low restarts the count from zero.
- R2: Undervoltage trips at the fourth consecutive unblanked strobe with `uvp_hit` high (count `UVP_STREAK`). A clean strobe restarts the count.
- R3: `uvp_hit` is ignored for `BLANK_CYC` clocks after reset and again after each restart (entry to RUN from CHARGE or THERM).
- R4: The first strobe with `ocp_hit` high enters a warning. If the next strobe is clean the warning is dropped. If the next strobe also has `ocp_hit` high, the block trips.
- R5: Auto-restart sequence. After a trip to DRAIN, `shutdown_req`=1 and `recharge_req`=0, and `sup_at_on` is ignored. Once `sup_below_rst` is seen, `recharge_req`=1 until `sup_at_on`, and then switching resumes.
- R6: With `ovp_latch_cfg`=1, an overvoltage trip holds the block shut for as long as `mains_ok`=1. Inside LATCH, `recharge_req` is set by `sup_below_off` and cleared by `sup_at_on`. LATCH is left only when `sup_below_rst` is seen with `mains_ok`=0, which moves the block to CHARGE.
- R7: An `otp_hot` strobe stops switching. Inside THERM, `recharge_req` is set by `sup_below_rst` and cleared by `sup_at_on`. The block resumes only on `sup_at_on` while `otp_hot`=0.
- R8: When several faults qualify on the same strobe, the winner is chosen in the order overcurrent, overvoltage, over-temperature, undervoltage. Only the winner's status bit is set. The status bits stay fixed until restart and are cleared at restart.
- R9: Counters and the warning state advance only on `cyc_end`. Flag values between strobes have no effect.
- R10: After reset, `shutdown_req`, `recharge_req` and all status bits are 0 and the block is in RUN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset (power-on) |
| cyc_end | input | 1 | One-clock strobe at the end of each switching cycle |
| ovp_hit | input | 1 | Overvoltage comparator sample |
| uvp_hit | input | 1 | Undervoltage comparator sample (at or below threshold) |
| ocp_hit | input | 1 | Hiccup overcurrent comparator sample |
| otp_hot | input | 1 | Over-temperature flag, released after hysteresis |
| ovp_latch_cfg | input | 1 | 1 = latched overvoltage response, 0 = auto-restart |
| sup_below_rst | input | 1 | Supply below the restart level |
| sup_below_off | input | 1 | Supply below the off level |
| sup_at_on | input | 1 | Supply at the turn-on level |
| mains_ok | input | 1 | Input mains present |
| shutdown_req | output | 1 | Stop switching |
| recharge_req | output | 1 | Ask the startup generator to recharge the supply |
| stat_ocp | output | 1 | Sticky: overcurrent caused the stop |
| stat_ovp | output | 1 | Sticky: overvoltage caused the stop |
| stat_otp | output | 1 | Sticky: over-temperature caused the stop |
| stat_uvp | output | 1 | Sticky: undervoltage caused the stop |

## Verification
Overvoltage runs are applied in three forms:
- three hits then a clean cycle then four hits, which separates a consecutive count from a cumulative one;
- hits held high between strobes, which shows whether the count follows the strobe or the clock;
- undervoltage runs inside and outside the blanking window.

Overcurrent is tried as isolated single hits and as back-to-back hits. This distinguishes the warning state from an immediate trip.

Mixed patterns check the priority order and that only one status bit is set:
- overcurrent together with overvoltage;
- overcurrent warning together with over-temperature;
- a fourth overvoltage hit together with over-temperature.

The supply-flag sequences are walked through all three stop paths. For each, the test shows which flags move the state, which ones are ignored, and when the status clears.

// File: rtl/fm_pkg.sv
package fm_pkg;

    typedef enum logic [2:0] {
        FM_RUN    = 3'd0,
        FM_DRAIN  = 3'd1,
        FM_CHARGE = 3'd2,
        FM_LATCH  = 3'd3,
        FM_THERM  = 3'd4
    } fm_state_e;

    typedef struct packed {
        logic ocp;
        logic ovp;
        logic otp;
        logic uvp;
    } fm_fault_t;

endpackage

// File: rtl/fm_streak_qual.sv
module fm_streak_qual #(
    parameter int STREAK = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic strobe,
    input  logic hit,
    output logic trip
);
    localparam int CW = $clog2(STREAK + 1);
    localparam logic [CW-1:0] LAST = CW'(STREAK - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!en) begin
            cnt_q <= '0;
        end else if (strobe) begin
            if (!hit)              cnt_q <= '0;
            else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
        end
    end

    assign trip = en && strobe && hit && (cnt_q == LAST);

    // R1 / R2: a clean strobe restarts the streak
    assert_clean_cycle_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (en && strobe && !hit) |=> (cnt_q == '0));

    // R9: no strobe, no progress
    assert_no_advance_without_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !strobe) |=> $stable(cnt_q));

endmodule

// File: rtl/fm_twostrike.sv
module fm_twostrike (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic strobe,
    input  logic hit,
    output logic trip
);
    typedef enum logic {TS_IDLE = 1'b0, TS_WARN = 1'b1} ts_state_e;

    ts_state_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= TS_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        if (!en) begin
            st_d = TS_IDLE;
        end else if (strobe) begin
            unique case (st_q)
                TS_IDLE: st_d = hit ? TS_WARN : TS_IDLE;
                TS_WARN: st_d = hit ? TS_WARN : TS_IDLE;
                default: st_d = TS_IDLE;
            endcase
        end
    end

    assign trip = en && strobe && hit && (st_q == TS_WARN);

    // R4: the first hit only warns
    assert_first_hit_warns_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && strobe && hit && st_q == TS_IDLE) |-> !trip ##1 (st_q == TS_WARN));

    // R4: a clean cycle drops the warning
    assert_clean_drops_warn_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && strobe && !hit) |=> (st_q == TS_IDLE));

endmodule

// File: rtl/fm_blank_timer.sv
module fm_blank_timer #(
    parameter int BLANK_CYC = 2_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic active
);
    localparam int CW = $clog2(BLANK_CYC + 1);
    localparam logic [CW-1:0] START = CW'(BLANK_CYC);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    cnt_q <= START;
        else if (load)                 cnt_q <= START;
        else if (run && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign active = (cnt_q != '0);

    // R3: every restart reopens the window
    assert_restart_reloads_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (active && cnt_q == START));

endmodule

// File: rtl/flyback_fault_mgr.sv
module flyback_fault_mgr
    import fm_pkg::*;
#(
    parameter int OVP_STREAK = 4,
    parameter int UVP_STREAK = 4,
    parameter int BLANK_CYC  = 2_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cyc_end,
    input  logic ovp_hit,
    input  logic uvp_hit,
    input  logic ocp_hit,
    input  logic otp_hot,
    input  logic ovp_latch_cfg,
    input  logic sup_below_rst,
    input  logic sup_below_off,
    input  logic sup_at_on,
    input  logic mains_ok,
    output logic shutdown_req,
    output logic recharge_req,
    output logic stat_ocp,
    output logic stat_ovp,
    output logic stat_otp,
    output logic stat_uvp
);
    fm_state_e state_q, state_d;
    fm_fault_t win, status_q;
    logic      running, restart, blank_active;
    logic      ovp_trip, uvp_trip, ocp_trip, otp_trip;
    logic      recharge_q;

    assign running = (state_q == FM_RUN);
    assign restart = !running && (state_d == FM_RUN);

    // ---------------- qualifiers ----------------
    fm_streak_qual #(.STREAK(OVP_STREAK)) u_ovp_qual (
        .clk(clk), .rst_n(rst_n), .en(running),
        .strobe(cyc_end), .hit(ovp_hit), .trip(ovp_trip)
    );

    fm_streak_qual #(.STREAK(UVP_STREAK)) u_uvp_qual (
        .clk(clk), .rst_n(rst_n), .en(running && !blank_active),
        .strobe(cyc_end), .hit(uvp_hit), .trip(uvp_trip)
    );

    fm_twostrike u_ocp_qual (
        .clk(clk), .rst_n(rst_n), .en(running),
        .strobe(cyc_end), .hit(ocp_hit), .trip(ocp_trip)
    );

    fm_blank_timer #(.BLANK_CYC(BLANK_CYC)) u_blank (
        .clk(clk), .rst_n(rst_n), .load(restart),
        .run(running), .active(blank_active)
    );

    assign otp_trip = running && cyc_end && otp_hot;

    // ---------------- priority pick ----------------
    always_comb begin
        win     = '0;
        win.ocp = ocp_trip;
        win.ovp = ovp_trip && !ocp_trip;
        win.otp = otp_trip && !ocp_trip && !ovp_trip;
        win.uvp = uvp_trip && !ocp_trip && !ovp_trip && !otp_trip;
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FM_RUN;
        else        state_q <= state_d;
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FM_RUN: begin
                if (win.ocp)      state_d = FM_DRAIN;
                else if (win.ovp) state_d = ovp_latch_cfg ? FM_LATCH : FM_DRAIN;
                else if (win.otp) state_d = FM_THERM;
                else if (win.uvp) state_d = FM_DRAIN;
            end
            FM_DRAIN:  if (sup_below_rst)              state_d = FM_CHARGE;
            FM_CHARGE: if (sup_at_on)                  state_d = FM_RUN;
            FM_LATCH:  if (sup_below_rst && !mains_ok) state_d = FM_CHARGE;
            FM_THERM:  if (!otp_hot && sup_at_on)      state_d = FM_RUN;
            default:                                   state_d = FM_RUN;
        endcase
    end

    // ---------------- outputs ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            recharge_q <= 1'b0;
            status_q   <= '0;
        end else begin
            unique case (state_d)
                FM_RUN, FM_DRAIN: recharge_q <= 1'b0;
                FM_CHARGE:        recharge_q <= 1'b1;
                FM_LATCH: begin
                    if (state_q != FM_LATCH) recharge_q <= 1'b0;
                    else if (sup_below_off)  recharge_q <= 1'b1;
                    else if (sup_at_on)      recharge_q <= 1'b0;
                end
                FM_THERM: begin
                    if (state_q != FM_THERM) recharge_q <= 1'b0;
                    else if (sup_below_rst)  recharge_q <= 1'b1;
                    else if (sup_at_on)      recharge_q <= 1'b0;
                end
                default:          recharge_q <= 1'b0;
            endcase

            if (restart)                        status_q <= '0;
            else if (running && !(state_d == FM_RUN)) status_q <= win;
        end
    end

    assign shutdown_req = !running;
    assign recharge_req = recharge_q;
    assign stat_ocp     = status_q.ocp;
    assign stat_ovp     = status_q.ovp;
    assign stat_otp     = status_q.otp;
    assign stat_uvp     = status_q.uvp;

    // ---------------- assertions ----------------
    // R8: one cause at most
    assert_status_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(status_q));

    // R8: cause is frozen while stopped
    assert_status_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && $past(state_q) != FM_RUN) |-> $stable(status_q));

    // R3: undervoltage cannot qualify inside the window
    assert_blank_masks_uvp_R3: assert property (@(posedge clk) disable iff (!rst_n)
        blank_active |-> !uvp_trip);

    // R6: latched stop holds while mains is present
    assert_latch_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FM_LATCH && mains_ok) |=> (state_q == FM_LATCH));

    // R5: no recharge while switching or draining
    assert_no_recharge_run_drain_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FM_RUN || state_q == FM_DRAIN) |-> !recharge_req);

    // R9: leaving RUN needs a strobe
    assert_stop_on_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (running && state_d != FM_RUN) |-> cyc_end);

endmodule

// File: tb/flyback_fault_mgr_bench.sv
`timescale 1ns/1ps
module flyback_fault_mgr_bench;

    localparam int BLANK = 30;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cyc_end = 0, ovp_hit = 0, uvp_hit = 0, ocp_hit = 0, otp_hot = 0;
    logic ovp_latch_cfg = 0, sup_below_rst = 0, sup_below_off = 0, sup_at_on = 0;
    logic mains_ok = 1;
    logic shutdown_req, recharge_req, stat_ocp, stat_ovp, stat_otp, stat_uvp;

    int total = 0;
    int fails = 0;

    always #4 clk = ~clk;

    flyback_fault_mgr #(.OVP_STREAK(4), .UVP_STREAK(4), .BLANK_CYC(BLANK)) u_flyback_fault_mgr (
        .clk(clk), .rst_n(rst_n), .cyc_end(cyc_end),
        .ovp_hit(ovp_hit), .uvp_hit(uvp_hit), .ocp_hit(ocp_hit), .otp_hot(otp_hot),
        .ovp_latch_cfg(ovp_latch_cfg), .sup_below_rst(sup_below_rst),
        .sup_below_off(sup_below_off), .sup_at_on(sup_at_on), .mains_ok(mains_ok),
        .shutdown_req(shutdown_req), .recharge_req(recharge_req),
        .stat_ocp(stat_ocp), .stat_ovp(stat_ovp), .stat_otp(stat_otp), .stat_uvp(stat_uvp)
    );

    // {rst_first, ovp, uvp, ocp, otp, exp_shut, exp_stat(ocp,ovp,otp,uvp)}
    localparam logic [9:0] VEC [20] = '{
        10'b1_1000_0_0000, 10'b0_1000_0_0000, 10'b0_1000_0_0000, 10'b0_0000_0_0000,
        10'b0_1000_0_0000, 10'b0_1000_0_0000, 10'b0_1000_0_0000, 10'b0_1000_1_0100,
        10'b1_0010_0_0000, 10'b0_0000_0_0000, 10'b0_0010_0_0000, 10'b0_0010_1_1000,
        10'b1_0001_1_0010, 10'b1_0011_1_0010, 10'b1_1010_0_0000, 10'b0_1010_1_1000,
        10'b1_1000_0_0000, 10'b0_1000_0_0000, 10'b0_1000_0_0000, 10'b0_1001_1_0100
    };

    function automatic logic [5:0] obs();
        return {shutdown_req, recharge_req, stat_ocp, stat_ovp, stat_otp, stat_uvp};
    endfunction

    task automatic check(input string tag, input logic [5:0] exp);
        total++;
        if (obs() !== exp) begin
            fails++;
            $display("FAIL %s: got shut/rech/stat=%b expected %b", tag, obs(), exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        {ovp_hit, uvp_hit, ocp_hit, otp_hot, cyc_end} = '0;
        {sup_below_rst, sup_below_off, sup_at_on} = '0;
        mains_ok = 1'b1;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic strobe(input logic o, input logic u, input logic c, input logic t);
        @(negedge clk);
        ovp_hit = o; uvp_hit = u; ocp_hit = c; otp_hot = t; cyc_end = 1'b1;
        @(negedge clk);
        cyc_end = 1'b0; ovp_hit = 0; uvp_hit = 0; ocp_hit = 0; otp_hot = 0;
    endtask

    task automatic pulse_rst();
        @(negedge clk); sup_below_rst = 1;
        @(negedge clk); sup_below_rst = 0;
    endtask
    task automatic pulse_off();
        @(negedge clk); sup_below_off = 1;
        @(negedge clk); sup_below_off = 0;
    endtask
    task automatic pulse_on();
        @(negedge clk); sup_at_on = 1;
        @(negedge clk); sup_at_on = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog: got hung expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        // R10 reset state
        do_reset();
        check("R10 reset state", 6'b00_0000);

        // table: R1 streak/reset, R4 two-strike, R8 priority, R7 otp trip
        for (int i = 0; i < 20; i++) begin
            if (VEC[i][9]) do_reset();
            strobe(VEC[i][8], VEC[i][7], VEC[i][6], VEC[i][5]);
            check($sformatf("R1/R4/R8 vector %0d", i), {VEC[i][4], 1'b0, VEC[i][3:0]});
        end

        // R9: hits held between strobes do not count
        do_reset();
        @(negedge clk); ovp_hit = 1;
        repeat (10) @(negedge clk);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); cyc_end = 1;
            @(negedge clk); cyc_end = 0;
        end
        repeat (5) @(negedge clk);
        check("R9 only strobes count", 6'b00_0000);
        @(negedge clk); cyc_end = 1;
        @(negedge clk); cyc_end = 0; ovp_hit = 0;
        check("R9 fourth strobe trips", 6'b10_0100);

        // R5: auto-restart path
        pulse_on();
        check("R5 at_on ignored while draining", 6'b10_0100);
        pulse_rst();
        check("R5 recharge after drop", 6'b11_0100);
        pulse_on();
        check("R5 resume and R8 status cleared", 6'b00_0000);

        // R3: blanking after restart, R2 count
        for (int k = 0; k < 4; k++) strobe(0, 1, 0, 0);
        check("R3 uvp blanked after restart", 6'b00_0000);
        repeat (BLANK + 5) @(negedge clk);
        for (int k = 0; k < 3; k++) strobe(0, 1, 0, 0);
        check("R2 three uvp no trip", 6'b00_0000);
        strobe(0, 1, 0, 0);
        check("R2 fourth uvp trips", 6'b10_0001);

        // R3: blanking after power-on
        do_reset();
        for (int k = 0; k < 4; k++) strobe(0, 1, 0, 0);
        check("R3 uvp blanked after reset", 6'b00_0000);
        repeat (BLANK + 5) @(negedge clk);
        strobe(0, 1, 0, 0); strobe(0, 1, 0, 0); strobe(0, 0, 0, 0);
        strobe(0, 1, 0, 0); strobe(0, 1, 0, 0); strobe(0, 1, 0, 0);
        check("R2 clean cycle restarts uvp count", 6'b00_0000);

        // R6: latched overvoltage
        do_reset();
        ovp_latch_cfg = 1;
        for (int k = 0; k < 4; k++) strobe(1, 0, 0, 0);
        check("R6 latched trip", 6'b10_0100);
        pulse_rst();
        check("R6 mains present holds latch", 6'b10_0100);
        pulse_off();
        check("R6 recharge on off level", 6'b11_0100);
        pulse_on();
        check("R6 recharge stops at on level", 6'b10_0100);
        @(negedge clk); mains_ok = 0;
        pulse_rst();
        check("R6 mains removed releases latch", 6'b11_0100);
        mains_ok = 1;
        pulse_on();
        check("R6 restart clears", 6'b00_0000);
        ovp_latch_cfg = 0;

        // R7: thermal stop
        do_reset();
        strobe(0, 0, 0, 1);
        @(negedge clk); otp_hot = 1;
        pulse_rst();
        check("R7 recharge at restart level", 6'b11_0010);
        pulse_on();
        check("R7 hot holds stop", 6'b10_0010);
        @(negedge clk); otp_hot = 0;
        pulse_on();
        check("R7 cooled resumes", 6'b00_0000);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule